// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block finds the clock setting that comes closest to a requested frequency. Each setting is made of one of two fixed source clocks, an odd divider and a power-of-two shift. The request is an integer in hertz. The block tries every legal setting in turn, using one serial divider that it shares between them. At the end it reports the best setting and the frequency that setting really produces.

A caller drives `req_hz` and `is_panel` and pulses `start`. The block then holds `busy` high while it walks the candidate list. When the walk ends it raises `done` for one cycle, and the result ports keep their values until the next search. A mode-setting routine normally asks for twice the pixel clock and halves the frequency that comes back. That step belongs to the caller.

Top module: `pclk_search`

## Requirements
- R1: After reset, `busy`, `done`, `src_sel`, `div_code`, `shift_amt` and `freq_hz` are all zero.
- R2: A `start` seen while idle makes `busy` high in the next cycle. A `start` seen while busy is ignored: the running search keeps its latched request and display type, and it produces exactly one `done` pulse.
- R3: With `is_panel`=0 (CRT), only the dividers 1 and 3 are candidates, so `div_code` is never 2 in the result.
- R4: With `is_panel`=1 (panel), divider 5 is a candidate as well, so a request equal to a source clock divided by 5 selects `div_code`=2.
- R5: Each candidate is scored as |round(src/(div<<shift)) - req_hz|, with round(n/d) = floor((2n+d)/(2d)). The result is the candidate with the lowest score. Shift takes the values 0 to 7.
- R6: Candidates are walked with the source as the outermost loop (288 MHz, then 336 MHz), then the divider in ascending order, then the shift from 0 to 7. A candidate wins only on a strictly lower score, so on a tie the first one in this walk order is kept.
- R7: `freq_hz` reports the truncated value floor(src/(div<<shift)) of the chosen setting, not the rounded one.
- R8: `done` lasts exactly one cycle, falls in the cycle after the last candidate is scored, and is never high together with `busy`. While the block is idle and no search is started, the result ports do not change.
- R9: The encodings are: `src_sel` 0 = 288 MHz and 1 = 336 MHz; `div_code` 0, 1 and 2 mean dividers 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search; ignored while busy |
| is_panel | input | 1 | 1 = panel divider set, 0 = CRT divider set |
| req_hz | input | 32 | Requested frequency in hertz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| src_sel | output | 1 | Chosen source clock |
| div_code | output | 2 | Chosen odd divider, encoded |
| shift_amt | output | 3 | Chosen power-of-two shift |
| freq_hz | output | 32 | Truncated frequency of the chosen setting |

## Verification
The hardest cases to reach are an exact tie between two candidates and a `start` that arrives in the middle of a search. A directed request at the midpoint of the two undivided sources forces the tie. A second, different request with the other display type is injected 20 cycles into a run to show the ignore rule. Requests at a source divided by 5 separate the panel walk from the CRT walk. Seeded random requests over the whole output range check the scoring against a bench model that uses the rounded-division formula directly.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } srch_st_e;

    // Odd divider value for a divider code: 0->1, 1->3, 2->5
    function automatic logic [2:0] odd_div(input logic [1:0] code);
        return {code, 1'b1};
    endfunction

endpackage

// File: rtl/pclk_cand_map.sv
module pclk_cand_map #(
    parameter int unsigned FW      = 32,
    parameter int unsigned SHW     = 3,
    parameter int unsigned DENW    = 10,
    parameter int unsigned SRC0_HZ = 288000000,
    parameter int unsigned SRC1_HZ = 336000000
) (
    input  logic            src_sel,
    input  logic [1:0]      div_code,
    input  logic [SHW-1:0]  shift_amt,
    output logic [FW-1:0]   numer,
    output logic [DENW-1:0] denom
);
    import pclk_pkg::*;

    always_comb begin
        numer = src_sel ? FW'(SRC1_HZ) : FW'(SRC0_HZ);
        denom = DENW'(odd_div(div_code)) << shift_amt;
    end

endmodule

// File: rtl/pclk_divu.sv
module pclk_divu #(
    parameter int unsigned NW = 32,
    parameter int unsigned DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          valid,
    output logic [NW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int unsigned CW = $clog2(NW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [NW-1:0] q;
        logic [DW-1:0] r;
        logic [DW-1:0] d;
        logic          act;
        logic          vld;
    } div_t;

    div_t cur_q, cur_d;
    logic [DW:0] trial;
    logic        ge;

    always_comb begin
        cur_d     = cur_q;
        cur_d.vld = 1'b0;
        trial     = {cur_q.r, cur_q.q[NW-1]};
        ge        = trial >= {1'b0, cur_q.d};
        if (cur_q.act) begin
            cur_d.q   = {cur_q.q[NW-2:0], ge};
            cur_d.r   = ge ? DW'(trial - {1'b0, cur_q.d}) : trial[DW-1:0];
            cur_d.cnt = cur_q.cnt - 1'b1;
            if (cur_q.cnt == CW'(1)) begin
                cur_d.act = 1'b0;
                cur_d.vld = 1'b1;
            end
        end else if (go) begin
            cur_d.q   = num;
            cur_d.r   = '0;
            cur_d.d   = den;
            cur_d.cnt = CW'(NW);
            cur_d.act = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign valid = cur_q.vld;
    assign quo   = cur_q.q;
    assign rem   = cur_q.r;

endmodule

// File: rtl/pclk_score.sv
module pclk_score #(
    parameter int unsigned FW   = 32,
    parameter int unsigned DENW = 10
) (
    input  logic [FW-1:0]   quo,
    input  logic [DENW-1:0] rem,
    input  logic [DENW-1:0] den,
    input  logic [FW-1:0]   req,
    input  logic [FW-1:0]   best_diff,
    output logic [FW-1:0]   diff,
    output logic            better
);
    logic [FW-1:0] rounded;

    always_comb begin
        // floor(n/d + 1/2) = q + (2r >= d)
        rounded = quo + FW'({rem, 1'b0} >= {1'b0, den});
        diff    = (rounded >= req) ? (rounded - req) : (req - rounded);
        better  = diff < best_diff;
    end

endmodule

// File: rtl/pclk_search.sv
module pclk_search #(
    parameter int unsigned FW      = 32,
    parameter int unsigned SHW     = 3,
    parameter int unsigned SRC0_HZ = 288000000,
    parameter int unsigned SRC1_HZ = 336000000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_panel,
    input  logic [FW-1:0]  req_hz,
    output logic           busy,
    output logic           done,
    output logic           src_sel,
    output logic [1:0]     div_code,
    output logic [SHW-1:0] shift_amt,
    output logic [FW-1:0]  freq_hz
);
    import pclk_pkg::*;

    localparam int unsigned NSHIFT = 1 << SHW;
    localparam int unsigned DENW   = 3 + NSHIFT - 1;
    localparam logic [SHW-1:0] SH_LAST = SHW'(NSHIFT - 1);

    typedef struct packed {
        srch_st_e       st;
        logic           panel;
        logic [FW-1:0]  req;
        logic           c_src;
        logic [1:0]     c_div;
        logic [SHW-1:0] c_sh;
        logic           b_src;
        logic [1:0]     b_div;
        logic [SHW-1:0] b_sh;
        logic [FW-1:0]  b_freq;
        logic [FW-1:0]  b_diff;
        logic           done;
    } srch_t;

    srch_t s_q, s_d;

    logic [FW-1:0]   numer;
    logic [DENW-1:0] denom;
    logic            div_go, div_vld;
    logic [FW-1:0]   div_quo;
    logic [DENW-1:0] div_rem;
    logic [FW-1:0]   cand_diff;
    logic            cand_better;
    logic [1:0]      div_last;

    pclk_cand_map #(
        .FW(FW), .SHW(SHW), .DENW(DENW), .SRC0_HZ(SRC0_HZ), .SRC1_HZ(SRC1_HZ)
    ) u_map (
        .src_sel(s_q.c_src), .div_code(s_q.c_div), .shift_amt(s_q.c_sh),
        .numer(numer), .denom(denom)
    );

    pclk_divu #(.NW(FW), .DW(DENW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(numer), .den(denom),
        .valid(div_vld), .quo(div_quo), .rem(div_rem)
    );

    pclk_score #(.FW(FW), .DENW(DENW)) u_score (
        .quo(div_quo), .rem(div_rem), .den(denom), .req(s_q.req),
        .best_diff(s_q.b_diff), .diff(cand_diff), .better(cand_better)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        div_go   = 1'b0;
        div_last = s_q.panel ? 2'd2 : 2'd1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st     = ST_ISSUE;
                    s_d.panel  = is_panel;
                    s_d.req    = req_hz;
                    s_d.c_src  = 1'b0;
                    s_d.c_div  = 2'd0;
                    s_d.c_sh   = '0;
                    s_d.b_diff = '1;
                end
            end
            ST_ISSUE: begin
                div_go = 1'b1;
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_vld) begin
                    if (cand_better) begin
                        s_d.b_src  = s_q.c_src;
                        s_d.b_div  = s_q.c_div;
                        s_d.b_sh   = s_q.c_sh;
                        s_d.b_freq = div_quo;
                        s_d.b_diff = cand_diff;
                    end
                    s_d.st = ST_ISSUE;
                    if (s_q.c_sh != SH_LAST) begin
                        s_d.c_sh = s_q.c_sh + 1'b1;
                    end else begin
                        s_d.c_sh = '0;
                        if (s_q.c_div != div_last) begin
                            s_d.c_div = s_q.c_div + 1'b1;
                        end else if (!s_q.c_src) begin
                            s_d.c_div = 2'd0;
                            s_d.c_src = 1'b1;
                        end else begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign src_sel   = s_q.b_src;
    assign div_code  = s_q.b_div;
    assign shift_amt = s_q.b_sh;
    assign freq_hz   = s_q.b_freq;

endmodule

// File: rtl/pclk_search_chk.sv
module pclk_search_chk #(
    parameter int unsigned FW      = 32,
    parameter int unsigned SHW     = 3,
    parameter int unsigned SRC0_HZ = 288000000,
    parameter int unsigned SRC1_HZ = 336000000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           src_sel,
    input logic [1:0]     div_code,
    input logic [SHW-1:0] shift_amt,
    input logic [FW-1:0]  freq_hz
);
    logic [FW-1:0] trunc_exp;
    always_comb begin
        trunc_exp = (src_sel ? FW'(SRC1_HZ) : FW'(SRC0_HZ)) /
                    (FW'({div_code, 1'b1}) << shift_amt);
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(freq_hz) && $stable(src_sel) &&
                               $stable(div_code) && $stable(shift_amt)));

    assert_trunc_freq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (freq_hz == trunc_exp));

    assert_div_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_code != 2'd3));

endmodule

bind pclk_search pclk_search_chk #(
    .FW(FW), .SHW(SHW), .SRC0_HZ(SRC0_HZ), .SRC1_HZ(SRC1_HZ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .src_sel(src_sel), .div_code(div_code), .shift_amt(shift_amt), .freq_hz(freq_hz)
);

// File: tb/pclk_search_tb.sv
module pclk_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_panel = 1'b0;
    logic [31:0] req_hz = '0;
    logic        busy, done, src_sel;
    logic [1:0]  div_code;
    logic [2:0]  shift_amt;
    logic [31:0] freq_hz;

    int checks = 0;
    int errors = 0;
    localparam int RUN_LIMIT = 5000;

    always #4 clk = ~clk;

    pclk_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_panel(is_panel), .req_hz(req_hz),
        .busy(busy), .done(done), .src_sel(src_sel), .div_code(div_code),
        .shift_amt(shift_amt), .freq_hz(freq_hz)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model: walk per R5/R6 with the rounded-division formula, strict-less update
    task automatic model(input longint req, input bit panel, output bit e_src,
                         output logic [1:0] e_dc, output logic [2:0] e_sh, output longint e_f);
        longint best = 64'h7fffffffffffffff;
        e_src = 0; e_dc = 0; e_sh = 0; e_f = 0;
        for (int s = 0; s < 2; s++) begin
            for (int dc = 0; dc <= (panel ? 2 : 1); dc++) begin
                for (int sh = 0; sh < 8; sh++) begin
                    longint src = (s == 0) ? 288000000 : 336000000;
                    longint den = longint'(2 * dc + 1) << sh;
                    longint rnd = (2 * src + den) / (2 * den);
                    longint df  = (rnd > req) ? rnd - req : req - rnd;
                    if (df < best) begin
                        best = df; e_src = bit'(s); e_dc = 2'(dc); e_sh = 3'(sh);
                        e_f = src / den;
                    end
                end
            end
        end
    endtask

    task automatic run_one(input logic [31:0] req, input bit panel, input bit poke, input string tag);
        bit e_src; logic [1:0] e_dc; logic [2:0] e_sh; longint e_f;
        int cyc = 0;
        int ndone = 0;
        model(longint'(req), panel, e_src, e_dc, e_sh, e_f);
        @(negedge clk);
        req_hz = req; is_panel = panel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
        while (!done && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 20) begin
                start = 1'b1; req_hz = ~req; is_panel = ~panel;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (done) ndone++;
        chk(done == 1'b1, {"R8 done reached (watchdog) ", tag}, done, 1);
        chk(src_sel == e_src, {"R5/R9 src_sel ", tag}, src_sel, e_src);
        chk(div_code == e_dc, {"R5/R9 div_code ", tag}, div_code, e_dc);
        chk(shift_amt == e_sh, {"R5 shift_amt ", tag}, shift_amt, e_sh);
        chk(longint'(freq_hz) == e_f, {"R7 freq_hz ", tag}, freq_hz, e_f);
        if (!panel) chk(div_code != 2'd2, {"R3 crt divider set ", tag}, div_code, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done) ndone++;
            chk(busy == 1'b0, {"R8 idle after done ", tag}, busy, 0);
            chk(longint'(freq_hz) == e_f, {"R8 result held ", tag}, freq_hz, e_f);
        end
        chk(ndone == 1, {"R2/R8 single done pulse ", tag}, ndone, 1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
        chk(freq_hz == 0 && src_sel == 0 && div_code == 0 && shift_amt == 0,
            "R1 reset result", freq_hz, 0);

        run_one(32'd288000000, 1'b0, 1'b0, "exact src0 crt");
        run_one(32'd112000000, 1'b0, 1'b0, "exact src1/3 crt");
        run_one(32'd312000000, 1'b0, 1'b0, "R6 tie midpoint");
        chk(src_sel == 1'b0 && div_code == 0 && shift_amt == 0, "R6 earliest on tie", src_sel, 0);
        run_one(32'd57600000, 1'b1, 1'b0, "R4 panel div5");
        chk(div_code == 2'd2, "R4 panel picks divider 5", div_code, 2);
        run_one(32'd57600000, 1'b0, 1'b0, "R3 crt same request");
        run_one(32'd525000, 1'b1, 1'b0, "R7 smallest panel");
        run_one(32'd1, 1'b0, 1'b0, "tiny request");
        run_one(32'hFFFF_FFF0, 1'b1, 1'b0, "huge request");
        run_one(32'd90000000, 1'b0, 1'b1, "R2 start while busy crt");
        run_one(32'd45000000, 1'b1, 1'b1, "R2 start while busy panel");
        for (int n = 0; n < 20; n++) begin
            run_one($urandom_range(700000000, 300000), bit'($urandom & 1), 1'b0, "R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule